// File: doc/BRIEF.md
# Rhythm Game Key Timing Scorer

This block grades a player's timing on a twelve-key keyboard against a stored note pattern. Once per slow tick, a 12-bit row from song memory enters a seven-stage sliding window. Each bit of a row says whether the matching key should be sounding. Alongside the window, every key is sampled into a current and a previous register, so that a press or a release shows up as a change between two consecutive ticks.

Each key has its own checker, and a checker grades only edges. A press or release that falls inside the on-time zone of the window earns two points. One that misses that zone by a single stage earns one point. Any other press or release costs one point. Holding a key, or leaving it untouched, never changes the score. This includes ignoring a note completely. The twelve grades are added into a signed 8-bit running score that saturates at its limits. A clear input zeroes that score.

The block sits between the input synchronizers and the score display. The song memory and the game controller supply the rows, the tick and the clear.

Top module: `rhythm_scorer`

## Requirements
- R1: The window holds seven stages, indexed 0 to 6. Its order, from newest to oldest, is early1 (0), early2 (1), on-time 1 (2), on-time 2 (3), on-time 3 (4), late1 (5) and late2 (6). On each tick, `note_row` enters stage 0 and every stage moves one place older. The window does not change on cycles without a tick.
- R2: On each tick, `keys_in` is captured as the current sample and the old current sample becomes the previous sample. A press is previous 0 with current 1. A release is previous 1 with current 0. Key changes between ticks have no effect.
- R3: A press earns +2 when the key's note bit is high in any of stages 2, 3 or 4 and low in stage 5.
- R4: A release earns +2 when the key's note bit is high in any of stages 2, 3 or 4 and low in stage 1.
- R5: A press that misses the R3 window earns +1 when its bit is high in stage 5 and low in stage 6.
- R6: A release that misses the R4 window earns +1 when its bit is high in stage 1 and low in stage 0.
- R7: Every other press or release scores −1. A held key, an idle key and a note that is never played all score 0.
- R8: Each key's grade is a 2-bit code: 0 stands for −1, 1 for 0, 2 for +1 and 3 for +2. On a tick, the score grows by the sum of all twelve codes minus 12. The grade for a tick is computed from the window and key samples that were present before that tick. Keys are graded independently, so a chord can be partly right.
- R9: `score` is 8-bit two's complement. It can go negative, and it saturates at −128 and +127 instead of wrapping.
- R10: Reset sets the score to 0. `clear` forces the score to 0 on the next edge and wins over a tick in the same cycle. A clear does not stop the window and the key samples from advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Slow-tick enable, one cycle wide |
| clear | input | 1 | Zeroes the score, takes priority over tick |
| note_row | input | 12 | Note row for this tick, one bit per key |
| keys_in | input | 12 | Synchronized key levels, 1 = pressed |
| score | output | 8 | Running score, two's complement |

## Verification
The assertions assume that `tick` is a one-cycle pulse and that `keys_in` and `note_row` are already synchronous to `clk`. They also assume that nothing outside the block depends on values between ticks. The bench drives every input on the falling edge and raises `tick` for exactly one cycle per step. Between steps it deliberately toggles keys and rows while `tick` is low, to show that such changes are ignored. Clears are issued both with and without a tick present.

// File: rtl/rscore_pkg.sv
package rscore_pkg;

  localparam int STAGES = 7;
  localparam int ST_E1 = 0;
  localparam int ST_E2 = 1;
  localparam int ST_O1 = 2;
  localparam int ST_O2 = 3;
  localparam int ST_O3 = 4;
  localparam int ST_L1 = 5;
  localparam int ST_L2 = 6;

  typedef enum logic [1:0] {
    G_WRONG = 2'd0,
    G_NONE  = 2'd1,
    G_NEAR  = 2'd2,
    G_HIT   = 2'd3
  } grade_t;

  // Grade one key from its edge flags and its column of the note window.
  function automatic grade_t grade_key(input logic is_press, input logic is_lift,
                                       input logic [STAGES-1:0] col);
    logic in_zone;
    in_zone = col[ST_O1] | col[ST_O2] | col[ST_O3];
    if (is_press) begin
      if (in_zone && !col[ST_L1]) return G_HIT;
      if (col[ST_L1] && !col[ST_L2]) return G_NEAR;
      return G_WRONG;
    end
    if (is_lift) begin
      if (in_zone && !col[ST_E2]) return G_HIT;
      if (col[ST_E2] && !col[ST_E1]) return G_NEAR;
      return G_WRONG;
    end
    return G_NONE;
  endfunction

  // Add a biased code sum to the score, clamp to the 8-bit signed range.
  function automatic logic [7:0] sat_step(input logic [7:0] cur, input int code_sum,
                                          input int bias);
    int t;
    t = int'($signed(cur)) + code_sum - bias;
    if (t > 127) return 8'h7F;
    if (t < -128) return 8'h80;
    return 8'(t);
  endfunction

endpackage

// File: rtl/note_window.sv
module note_window
  import rscore_pkg::*;
#(
  parameter int KEYS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [KEYS-1:0]              row_in,
  output logic [KEYS-1:0][STAGES-1:0]  cols
);

  logic [STAGES-1:0][KEYS-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (tick) begin
      stage_q[0] <= row_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  for (genvar k = 0; k < KEYS; k++) begin : g_col
    for (genvar s = 0; s < STAGES; s++) begin : g_st
      assign cols[k][s] = stage_q[s][k];
    end
  end

  // R1
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(stage_q));

endmodule

// File: rtl/key_sampler.sv
module key_sampler #(
  parameter int KEYS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [KEYS-1:0] keys_in,
  output logic [KEYS-1:0] press_evt,
  output logic [KEYS-1:0] lift_evt
);

  logic [KEYS-1:0] cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (tick) begin
      cur_q  <= keys_in;
      prev_q <= cur_q;
    end
  end

  assign press_evt = cur_q & ~prev_q;
  assign lift_evt  = ~cur_q & prev_q;

  // R2
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(press_evt) && $stable(lift_evt)));

endmodule

// File: rtl/key_judge.sv
module key_judge
  import rscore_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_press,
  input  logic              is_lift,
  input  logic [STAGES-1:0] col,
  output logic [1:0]        code
);

  grade_t g;
  always_comb g = grade_key(is_press, is_lift, col);
  assign code = g;

  // R7
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_press || is_lift) |-> (code == 2'd1));

  // R3
  early_col_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_press && (col == '0)) |-> (code == 2'd0));

endmodule

// File: rtl/score_accum.sv
module score_accum
  import rscore_pkg::*;
#(
  parameter int KEYS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clear,
  input  logic [2*KEYS-1:0] codes,
  output logic [7:0]        score
);

  int         code_sum;
  logic [7:0] score_q;

  always_comb begin
    code_sum = 0;
    for (int k = 0; k < KEYS; k++) code_sum += int'(codes[2*k +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     score_q <= '0;
    else if (clear) score_q <= '0;
    else if (tick)  score_q <= sat_step(score_q, code_sum, KEYS);
  end

  assign score = score_q;

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (score_q == 8'h00));

  // R8
  score_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(score_q));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && !score_q[7]) |=>
      (int'($signed(score_q)) >= int'($signed($past(score_q))) - KEYS));

endmodule

// File: rtl/rhythm_scorer.sv
module rhythm_scorer
  import rscore_pkg::*;
#(
  parameter int KEYS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clear,
  input  logic [KEYS-1:0] note_row,
  input  logic [KEYS-1:0] keys_in,
  output logic [7:0]      score
);

  logic [KEYS-1:0][STAGES-1:0] cols;
  logic [KEYS-1:0]             press_evt, lift_evt;
  logic [2*KEYS-1:0]           codes;

  note_window #(.KEYS(KEYS)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick), .row_in(note_row), .cols(cols)
  );

  key_sampler #(.KEYS(KEYS)) u_keys (
    .clk(clk), .rst_n(rst_n), .tick(tick), .keys_in(keys_in),
    .press_evt(press_evt), .lift_evt(lift_evt)
  );

  for (genvar k = 0; k < KEYS; k++) begin : g_judge
    key_judge u_judge (
      .clk(clk), .rst_n(rst_n),
      .is_press(press_evt[k]), .is_lift(lift_evt[k]),
      .col(cols[k]), .code(codes[2*k +: 2])
    );
  end

  score_accum #(.KEYS(KEYS)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear),
    .codes(codes), .score(score)
  );

endmodule

// File: tb/tb_rhythm_scorer.sv
module tb_rhythm_scorer;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic        clear = 0;
  logic [11:0] note_row = '0;
  logic [11:0] keys_in = '0;
  logic [7:0]  score;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int    exp_q[$];
  string tag_q[$];

  logic [11:0] m_win [7];
  logic [11:0] m_cur, m_prev;
  int          m_score;

  always #2 clk = ~clk;

  rhythm_scorer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clear),
    .note_row(note_row), .keys_in(keys_in), .score(score)
  );

  function automatic int ref_points(bit pr, bit lf, bit e1, bit e2, bit o1, bit o2,
                                    bit o3, bit l1, bit l2);
    bit zone = o1 || o2 || o3;
    if (!pr && !lf) return 0;
    if (pr) return (zone && !l1) ? 2 : ((l1 && !l2) ? 1 : -1);
    return (zone && !e2) ? 2 : ((e2 && !e1) ? 1 : -1);
  endfunction

  task automatic check(input int got, input int expv, input string tag);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  // Monitor: compare each expected item one falling edge after its tick.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(int'($signed(score)), e, t);
    end
  end

  // Driver: one tick, with the model advanced from the pre-tick state.
  task automatic step(input logic [11:0] row, input logic [11:0] k, input bit clr,
                      input string tag);
    int d;
    @(negedge clk);
    note_row = row; keys_in = k; tick = 1; clear = clr;
    d = 0;
    for (int i = 0; i < 12; i++)
      d += ref_points(m_cur[i] && !m_prev[i], !m_cur[i] && m_prev[i],
                      m_win[0][i], m_win[1][i], m_win[2][i], m_win[3][i],
                      m_win[4][i], m_win[5][i], m_win[6][i]);
    if (clr) m_score = 0;
    else begin
      m_score = m_score + d;
      if (m_score > 127) m_score = 127;
      if (m_score < -128) m_score = -128;
    end
    for (int s = 6; s > 0; s--) m_win[s] = m_win[s-1];
    m_win[0] = row;
    m_prev = m_cur;
    m_cur = k;
    @(posedge clk);
    #1;
    tick = 0; clear = 0;
    exp_q.push_back(m_score);
    tag_q.push_back(tag);
  endtask

  // Inputs wiggle without a tick, then are restored: score must not move.
  task automatic wiggle(input int n, input string tag);
    logic [11:0] kk, rr;
    @(negedge clk);
    kk = keys_in; rr = note_row;
    for (int i = 0; i < n; i++) begin
      keys_in = ~kk ^ 12'(i); note_row = ~rr;
      @(negedge clk);
    end
    keys_in = kk; note_row = rr;
    exp_q.push_back(m_score);
    tag_q.push_back(tag);
  endtask

  task automatic clear_only(input string tag);
    @(negedge clk);
    clear = 1;
    m_score = 0;
    @(posedge clk);
    #1;
    clear = 0;
    exp_q.push_back(m_score);
    tag_q.push_back(tag);
  endtask

  // One six-row note on nm, two key groups with press/lift tick indices.
  task automatic play(input logic [11:0] nm, input logic [11:0] ma, input int pa,
                      input int ra, input logic [11:0] mb, input int pb, input int rb,
                      input string tag);
    for (int i = 0; i < 16; i++) begin
      logic [11:0] row, k;
      row = (i >= 1 && i <= 6) ? nm : 12'h000;
      k = ((i >= pa && i < ra) ? ma : 12'h000) | ((i >= pb && i < rb) ? mb : 12'h000);
      step(row, k, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 7; s++) m_win[s] = '0;
    m_cur = '0; m_prev = '0; m_score = 0;
    repeat (3) @(negedge clk);
    check(int'($signed(score)), 0, "R10 reset value");
    rst_n = 1;
    @(negedge clk);

    // R3 R4: press and lift both on time on key 0 -> +4
    play(12'h001, 12'h001, 4, 9, 12'h000, 0, 0, "R3 R4 on-time press/lift");
    check(m_score, 4, "R3 R4 model total");
    // R5 R6: press one stage late, lift one stage early -> +2
    play(12'h002, 12'h002, 6, 7, 12'h000, 0, 0, "R5 R6 near press/lift");
    // R7: press too early, lift too late -> -2
    play(12'h004, 12'h004, 2, 12, 12'h000, 0, 0, "R7 wrong press/lift");
    // R7: note never played, no penalty
    play(12'h008, 12'h000, 0, 0, 12'h000, 0, 0, "R7 missed note");
    // R8: chord, one key on time and one key late
    play(12'h030, 12'h010, 3, 8, 12'h020, 7, 10, "R8 partial chord");
    // R1 R2: ticks spaced by wiggled idle cycles
    step(12'h000, 12'h040, 1'b0, "R2 press no note");
    wiggle(5, "R2 between-tick changes ignored");
    step(12'h000, 12'h040, 1'b0, "R1 R2 hold scores zero");
    wiggle(3, "R1 window frozen without tick");
    step(12'h000, 12'h000, 1'b0, "R7 stray lift");

    // R9: positive saturation with all twelve keys on time
    for (int r = 0; r < 4; r++)
      play(12'hFFF, 12'hFFF, 4, 9, 12'h000, 0, 0, "R9 climb");
    @(negedge clk);
    check(int'($signed(score)), 127, "R9 saturate high");
    // R9: button mashing drives score to the low limit
    for (int r = 0; r < 30; r++)
      step(12'h000, (r % 2 == 0) ? 12'hFFF : 12'h000, 1'b0, "R9 mash");
    @(negedge clk);
    check(int'($signed(score)), -128, "R9 saturate low");

    // R10: clear wins over a tick that would have scored
    step(12'h000, 12'h000, 1'b1, "R10 clear with tick");
    step(12'h000, 12'hFFF, 1'b0, "R10 after clear");
    step(12'h000, 12'h000, 1'b0, "R10 after clear lift");
    clear_only("R10 clear alone");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule